// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits next to a memory with two independent access ports, called left and right, and turns accesses to two reserved words at the top of the address space into a pair of doorbell interrupts. The left port leaves a message for the right port by writing the topmost word. The right port leaves a message for the left port by writing the word just below it. Each port gets an active-low interrupt that stays asserted until the receiving port performs a valid read of its own mailbox word. No control register is involved: the accesses alone set and clear the flags.

The logic is clocked. On every rising clock edge it samples the address and the active-low chip select, write strobe and output enable of each port. Each flag is a two-state machine. In `MBX_EMPTY` the interrupt is high. In `MBX_FULL` the interrupt is low. The machine moves from empty to full on the DEPOSIT transition, which is a write by the sending port to the mailbox word. It moves from full to empty on the COLLECT transition, which is a valid read by the receiving port when no deposit happens in the same cycle. In every other cycle it takes the HOLD transition and keeps its state. The interrupt pin is decoded straight from the state register.

Top module: `mbx_irq`

## Requirements
- R1: While reset is asserted, and afterwards until the first deposit, both `lft_irq_n` and `rgt_irq_n` are 1 (inactive).
- R2: A left access with `lft_sel_n`=0, `lft_wr_n`=0 and `lft_addr`=0x7FF (all ones) drives `rgt_irq_n` to 0 at the next rising clock edge.
- R3: A right access with `rgt_sel_n`=0, `rgt_wr_n`=1, `rgt_oe_n`=0 and `rgt_addr`=0x7FF drives `rgt_irq_n` to 1 at the next rising clock edge, unless R7 applies.
- R4: A right access with `rgt_sel_n`=0, `rgt_wr_n`=0 and `rgt_addr`=0x7FE (all ones except bit 0) drives `lft_irq_n` to 0 at the next rising clock edge.
- R5: A left access with `lft_sel_n`=0, `lft_wr_n`=1, `lft_oe_n`=0 and `lft_addr`=0x7FE drives `lft_irq_n` to 1 at the next rising clock edge, unless R7 applies.
- R6: A mailbox read with the chip select high or the output enable high clears nothing. A mailbox write with the chip select high sets nothing.
- R7: When a deposit and a collect for the same flag fall in the same cycle, the flag ends up set (low).
- R8: A port that writes its own receive word, reads the other port's word, or accesses any other address leaves both interrupts unchanged.
- R9: Each flag changes only through its own deposit and collect. An event for one flag never changes the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lft_addr | input | ADDR_W (11) | Left port address |
| lft_sel_n | input | 1 | Left chip select, active low |
| lft_wr_n | input | 1 | Left write strobe, active low |
| lft_oe_n | input | 1 | Left output enable, active low |
| rgt_addr | input | ADDR_W (11) | Right port address |
| rgt_sel_n | input | 1 | Right chip select, active low |
| rgt_wr_n | input | 1 | Right write strobe, active low |
| rgt_oe_n | input | 1 | Right output enable, active low |
| lft_irq_n | output | 1 | Interrupt to the left port, active low |
| rgt_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
Each interrupt pin is decoded straight from its state register. A wrong state therefore appears at the pin one clock after the access that caused it, and no later. A flag that misses a deposit stays high when it should be low. A flag that ignores a collect stays low after the read. A decoder that matches the wrong word or the wrong control combination flips a flag that should have held. The sweep applies every control combination at the mailbox words and at their neighbours, starting from both flag states, and checks both pins one cycle later. Any of these faults is therefore caught on the first access that exposes it.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

    typedef enum logic {
        MBX_EMPTY = 1'b0,
        MBX_FULL  = 1'b1
    } mbx_state_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_LFT  = 0;
    localparam int unsigned PORT_RGT  = 1;

endpackage

// File: rtl/mbx_port_decode.sv
`timescale 1ns/1ps
module mbx_port_decode #(
    parameter int unsigned       ADDR_W  = 11,
    parameter logic [ADDR_W-1:0] TX_ADDR = '1,
    parameter logic [ADDR_W-1:0] RX_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sel_n_i,
    input  logic              wr_n_i,
    input  logic              oe_n_i,
    output logic              deposit_o,
    output logic              collect_o
);

    logic active;

    always_comb begin
        active    = !sel_n_i;
        deposit_o = active && !wr_n_i && (addr_i == TX_ADDR);
        collect_o = active && wr_n_i && !oe_n_i && (addr_i == RX_ADDR);
    end

endmodule

// File: rtl/mbx_flag_fsm.sv
`timescale 1ns/1ps
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic deposit_i,
    input  logic collect_i,
    output logic irq_n_o
);

    mbx_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MBX_EMPTY: if (deposit_i) state_d = MBX_FULL;
            MBX_FULL:  if (collect_i && !deposit_i) state_d = MBX_EMPTY;
            default:   state_d = MBX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MBX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n_o = (state_q != MBX_FULL);
    end

endmodule

// File: rtl/mbx_irq.sv
`timescale 1ns/1ps
module mbx_irq
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_sel_n,
    input  logic              lft_wr_n,
    input  logic              lft_oe_n,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_sel_n,
    input  logic              rgt_wr_n,
    input  logic              rgt_oe_n,
    output logic              lft_irq_n,
    output logic              rgt_irq_n
);

    localparam logic [ADDR_W-1:0] LFT_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] RGT_BOX = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0]    addr_a [NUM_PORTS];
    logic [NUM_PORTS-1:0] sel_n_a, wr_n_a, oe_n_a;
    logic [NUM_PORTS-1:0] deposit, collect, irq_n;

    always_comb begin
        addr_a[PORT_LFT]  = lft_addr;
        addr_a[PORT_RGT]  = rgt_addr;
        sel_n_a           = {rgt_sel_n, lft_sel_n};
        wr_n_a            = {rgt_wr_n, lft_wr_n};
        oe_n_a            = {rgt_oe_n, lft_oe_n};
        lft_irq_n         = irq_n[PORT_LFT];
        rgt_irq_n         = irq_n[PORT_RGT];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] RX = (p == PORT_LFT) ? LFT_BOX : RGT_BOX;
        localparam logic [ADDR_W-1:0] TX = (p == PORT_LFT) ? RGT_BOX : LFT_BOX;

        mbx_port_decode #(
            .ADDR_W  (ADDR_W),
            .TX_ADDR (TX),
            .RX_ADDR (RX)
        ) dec_i (
            .addr_i    (addr_a[p]),
            .sel_n_i   (sel_n_a[p]),
            .wr_n_i    (wr_n_a[p]),
            .oe_n_i    (oe_n_a[p]),
            .deposit_o (deposit[p]),
            .collect_o (collect[p])
        );

        mbx_flag_fsm flag_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .deposit_i (deposit[NUM_PORTS-1-p]),
            .collect_i (collect[p]),
            .irq_n_o   (irq_n[p])
        );
    end

endmodule

// File: rtl/mbx_irq_chk.sv
`timescale 1ns/1ps
module mbx_irq_chk #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lft_addr,
    input logic              lft_sel_n,
    input logic              lft_wr_n,
    input logic              lft_oe_n,
    input logic [ADDR_W-1:0] rgt_addr,
    input logic              rgt_sel_n,
    input logic              rgt_wr_n,
    input logic              rgt_oe_n,
    input logic              lft_irq_n,
    input logic              rgt_irq_n
);

    localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

    logic put_r, take_r, put_l, take_l;
    always_comb begin
        put_r  = !lft_sel_n && !lft_wr_n && (lft_addr == BOX_R);
        take_r = !rgt_sel_n && rgt_wr_n && !rgt_oe_n && (rgt_addr == BOX_R);
        put_l  = !rgt_sel_n && !rgt_wr_n && (rgt_addr == BOX_L);
        take_l = !lft_sel_n && lft_wr_n && !lft_oe_n && (lft_addr == BOX_L);
    end

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (lft_irq_n && rgt_irq_n);
        end
    end

    // R2
    rgt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        put_r |=> !rgt_irq_n);

    // R4
    lft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        put_l |=> !lft_irq_n);

    // R3
    rgt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_r && !put_r) |=> rgt_irq_n);

    // R5
    lft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_l && !put_l) |=> lft_irq_n);

    // R8
    rgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!put_r && !take_r) |=> $stable(rgt_irq_n));

    // R9
    lft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!put_l && !take_l) |=> $stable(lft_irq_n));

endmodule

bind mbx_irq mbx_irq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lft_addr  (lft_addr),
    .lft_sel_n (lft_sel_n),
    .lft_wr_n  (lft_wr_n),
    .lft_oe_n  (lft_oe_n),
    .rgt_addr  (rgt_addr),
    .rgt_sel_n (rgt_sel_n),
    .rgt_wr_n  (rgt_wr_n),
    .rgt_oe_n  (rgt_oe_n),
    .lft_irq_n (lft_irq_n),
    .rgt_irq_n (rgt_irq_n)
);

// File: tb/mbx_irq_tb.sv
`timescale 1ns/1ps
module mbx_irq_tb_top;

    localparam int AW = 11;
    localparam logic [AW-1:0] MB_L = 11'h7FE;
    localparam logic [AW-1:0] MB_R = 11'h7FF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
    logic          lft_sel_n = 1'b1, lft_wr_n = 1'b1, lft_oe_n = 1'b1;
    logic          rgt_sel_n = 1'b1, rgt_wr_n = 1'b1, rgt_oe_n = 1'b1;
    logic          lft_irq_n, rgt_irq_n;

    int checks = 0;
    int errors = 0;
    logic pend_l = 1'b0, pend_r = 1'b0;

    always #4 clk = ~clk;

    mbx_irq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lft_addr(lft_addr), .lft_sel_n(lft_sel_n), .lft_wr_n(lft_wr_n), .lft_oe_n(lft_oe_n),
        .rgt_addr(rgt_addr), .rgt_sel_n(rgt_sel_n), .rgt_wr_n(rgt_wr_n), .rgt_oe_n(rgt_oe_n),
        .lft_irq_n(lft_irq_n), .rgt_irq_n(rgt_irq_n)
    );

    task automatic check_pin(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_both(input string tag);
        check_pin({tag, " lft_irq_n"}, lft_irq_n, !pend_l);
        check_pin({tag, " rgt_irq_n"}, rgt_irq_n, !pend_r);
    endtask

    // One access cycle on both ports; expected flags come from R2..R8.
    task automatic step(input logic [AW-1:0] la, input logic [2:0] lc,
                        input logic [AW-1:0] ra, input logic [2:0] rc);
        logic set_r, clr_r, set_l, clr_l;
        @(negedge clk);
        lft_addr = la; {lft_sel_n, lft_wr_n, lft_oe_n} = lc;
        rgt_addr = ra; {rgt_sel_n, rgt_wr_n, rgt_oe_n} = rc;
        set_r = (lc[2:1] == 2'b00) && (la == MB_R);
        clr_r = (rc == 3'b010) && (ra == MB_R);
        set_l = (rc[2:1] == 2'b00) && (ra == MB_L);
        clr_l = (lc == 3'b010) && (la == MB_L);
        @(negedge clk);
        pend_r = set_r || (pend_r && !clr_r);
        pend_l = set_l || (pend_l && !clr_l);
        lft_addr = '0; {lft_sel_n, lft_wr_n, lft_oe_n} = 3'b111;
        rgt_addr = '0; {rgt_sel_n, rgt_wr_n, rgt_oe_n} = 3'b111;
    endtask

    function automatic logic [AW-1:0] pick_addr(input int i);
        case (i)
            0:       return MB_L;
            1:       return MB_R;
            2:       return 11'h000;
            3:       return 11'h3FF;
            default: return 11'h7FD;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_both("R1 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_both("R1 after reset");

        // Directed: deposit and collect in each direction
        step(MB_R, 3'b001, '0, 3'b111);   check_both("R2 left deposit");
        step(MB_L, 3'b111, MB_L, 3'b001); check_both("R4 right deposit");
        step('0, 3'b111, MB_R, 3'b010);   check_both("R3 right collect");
        step(MB_L, 3'b010, '0, 3'b111);   check_both("R5 left collect");

        // R7: deposit and collect in the same cycle, from empty and from full
        step(MB_R, 3'b000, MB_R, 3'b010); check_both("R7 right flag from empty");
        step(MB_R, 3'b000, MB_R, 3'b010); check_both("R7 right flag from full");
        step(MB_L, 3'b010, MB_L, 3'b000); check_both("R7 left flag from empty");
        step(MB_L, 3'b010, MB_L, 3'b000); check_both("R7 left flag from full");

        // Sweep: acting port, starting state, every control code, five addresses
        for (int pi = 0; pi < 2; pi++) begin
            for (int st = 0; st < 2; st++) begin
                for (int ctl = 0; ctl < 8; ctl++) begin
                    for (int ai = 0; ai < 5; ai++) begin
                        if (st == 1) step(MB_R, 3'b001, MB_L, 3'b001);
                        else         step(MB_L, 3'b010, MB_R, 3'b010);
                        if (pi == 0) step(pick_addr(ai), 3'(ctl), '0, 3'b111);
                        else         step('0, 3'b111, pick_addr(ai), 3'(ctl));
                        check_both("R2/R3/R4/R5/R6/R8/R9 sweep");
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule